// File: doc/BRIEF.md
# Receive FIFO Pointer Status Tracker

This block keeps the bookkeeping for a message receive buffer of up to 64 elements whose usable size is set by a configuration input. It holds the write position, the read position, the number of stored elements, a full indication and a sticky message-lost indication. The receive logic raises a write request for each incoming message, and the host raises a read acknowledge each time it consumes the oldest element. The block does not store any message contents. It only decides where the next element goes, where the next one is taken from, and whether a message had to be dropped.

When the buffer is full, behaviour depends on an overwrite enable. In blocking operation the new message is dropped and the lost flag is raised. In overwrite operation the oldest element is replaced, both positions move on by one, and the lost flag is left alone. A configured size of zero means that no buffer exists, so every write attempt counts as a lost message. All state is presented as one packed read-only 32-bit status word.

The occupancy is tracked by a four-state machine. EMPTY holds no elements. PARTIAL holds at least one element and fewer than the size. FULL holds as many elements as the size. NOSIZE is used while the configured size is zero. The transitions are as follows. An accepted write moves EMPTY to PARTIAL, or to FULL when the size is one. A write that fills the last slot moves PARTIAL to FULL. A read moves FULL to PARTIAL, or to EMPTY when the size is one. A read of the last element moves PARTIAL to EMPTY. A size of zero moves any state to NOSIZE, and a nonzero size moves NOSIZE to EMPTY. An overwrite or a simultaneous write and read leaves FULL in FULL. The configured size is expected to change only while reset is asserted.

Top module: `rxq_ptr_status`

## Requirements
- R1: After reset every bit of the status word is 0. The bits outside the fields of R2, R3, R4 and R5 (bits 7, 15:14, 23:22 and 31:26) always read 0.
- R2: Bits 6:0 hold the fill level, the count of stored elements, which ranges from 0 to the effective size.
- R3: Bits 13:8 hold the get (read) index and bits 21:16 hold the put (write) index. Each index is 6 bits wide.
- R4: Bit 24 (full) is 1 exactly when, after the last clock edge, the fill level equals the effective size. With a size of zero the bit is 1 from the first edge after reset.
- R5: In blocking mode (overwrite enable 0), a write to a full buffer with no read in the same cycle sets bit 25 (lost) and changes no index and no fill level.
- R6: In overwrite mode (overwrite enable 1), a write to a full buffer advances both the get index and the put index by one, keeps the fill level, and leaves the lost flag unchanged.
- R7: A write while the effective size is zero sets the lost flag and leaves the indices and the fill level at 0.
- R8: The lost-clear input clears the lost flag at the next edge. If a lost event happens in the same cycle, the flag is set instead.
- R9: Both indices wrap from effective size minus 1 to 0.
- R10: A read acknowledge while the buffer is empty has no effect on the status word.
- R11: A write to a buffer that is not full advances the put index and increments the fill level at the same clock edge.
- R12: A write and a read in the same cycle advance both indices and keep the fill level. This holds also when the buffer is full: the read makes room and the lost flag is not set.
- R13: A configured size above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Receive logic requests to store one message |
| rd_ack | input | 1 | Host acknowledges reading the oldest element |
| cfg_size | input | 7 | Configured buffer size in elements (0 to 127, clamped to 64) |
| ovw_en | input | 1 | 1 selects overwrite mode, 0 selects blocking mode |
| lost_clr | input | 1 | Clears the lost flag |
| status_word | output | 32 | Packed status word: fill 6:0, get 13:8, put 21:16, full 24, lost 25 |

## Verification
The assertions check these properties on every cycle:
- the unused bits stay zero;
- the fill level never exceeds 64;
- the full bit agrees with the fill level and the size;
- a blocked overflow and a write at size zero both set the lost flag;
- an overwrite keeps the fill level and the lost flag;
- a clear without a write drops the lost flag;
- an empty read or an accepted write moves the status as stated.

Other behaviour shows only in the bench's scenarios, where a queue-based model is compared with the status word on every clock:
- the exact index values across wraps at sizes such as 8, 5 and a clamped 64;
- set-over-clear priority on the lost flag;
- simultaneous read and write on a full buffer;
- long mixed traffic.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2,
        ST_NOSIZE  = 2'd3
    } occ_state_t;

    localparam int STW_W    = 32;
    localparam int FILL_LSB = 0;
    localparam int GET_LSB  = 8;
    localparam int PUT_LSB  = 16;
    localparam int FULL_BIT = 24;
    localparam int LOST_BIT = 25;

endpackage

// File: rtl/rxq_index_ctr.sv
module rxq_index_ctr #(
    parameter int IDX_W = 6,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [LVL_W-1:0] size_eff,
    output logic [IDX_W-1:0] idx
);

    logic [LVL_W-1:0] last_pos;
    logic             at_last;

    assign last_pos = size_eff - LVL_W'(1);
    assign at_last  = (LVL_W'(idx) == last_pos);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (adv) begin
            idx <= at_last ? '0 : idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/rxq_lost_flag.sv
module rxq_lost_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_occ_fsm.sv
module rxq_occ_fsm
    import rxq_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_ack,
    input  logic             ovw_en,
    input  logic [LVL_W-1:0] size_eff,
    output logic             get_adv,
    output logic             put_adv,
    output logic             lost_evt,
    output logic             full,
    output logic [LVL_W-1:0] fill
);

    occ_state_t       state_q;
    occ_state_t       state_d;
    logic             fill_inc;
    logic             fill_dec;
    logic [LVL_W-1:0] fill_d;
    logic             no_size;

    assign no_size = (size_eff == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            fill    <= '0;
        end else begin
            state_q <= state_d;
            fill    <= fill_d;
        end
    end

    // per-state decisions
    always_comb begin
        get_adv  = 1'b0;
        put_adv  = 1'b0;
        lost_evt = 1'b0;
        fill_inc = 1'b0;
        fill_dec = 1'b0;
        if (no_size) begin
            lost_evt = wr_req;
        end else begin
            unique case (state_q)
                ST_EMPTY, ST_NOSIZE: begin
                    put_adv  = wr_req;
                    fill_inc = wr_req;
                end
                ST_PARTIAL: begin
                    get_adv  = rd_ack;
                    put_adv  = wr_req;
                    fill_inc = wr_req && !rd_ack;
                    fill_dec = rd_ack && !wr_req;
                end
                ST_FULL: begin
                    get_adv  = rd_ack || (wr_req && ovw_en);
                    put_adv  = wr_req && (rd_ack || ovw_en);
                    lost_evt = wr_req && !rd_ack && !ovw_en;
                    fill_dec = rd_ack && !wr_req;
                end
                default: begin
                    put_adv = 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        fill_d = fill;
        if (fill_inc) begin
            fill_d = fill + LVL_W'(1);
        end else if (fill_dec) begin
            fill_d = fill - LVL_W'(1);
        end
    end

    // next state
    always_comb begin
        if (no_size) begin
            state_d = ST_NOSIZE;
        end else if (fill_d == '0) begin
            state_d = ST_EMPTY;
        end else if (fill_d >= size_eff) begin
            state_d = ST_FULL;
        end else begin
            state_d = ST_PARTIAL;
        end
    end

    assign full = (state_q == ST_FULL) || (state_q == ST_NOSIZE);

endmodule

// File: rtl/rxq_ptr_status.sv
module rxq_ptr_status
    import rxq_pkg::*;
#(
    parameter int DEPTH_MAX = 64,
    parameter int IDX_W     = $clog2(DEPTH_MAX),
    parameter int LVL_W     = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_ack,
    input  logic [LVL_W-1:0] cfg_size,
    input  logic             ovw_en,
    input  logic             lost_clr,
    output logic [STW_W-1:0] status_word
);

    localparam int NUM_IDX = 2;  // 0: get, 1: put

    logic [LVL_W-1:0] size_eff;
    logic [LVL_W-1:0] fill;
    logic             full;
    logic             lost;
    logic             lost_evt;
    logic             get_adv;
    logic             put_adv;
    logic [NUM_IDX-1:0] adv_vec;
    logic [IDX_W-1:0]   idx_vec [NUM_IDX];

    assign size_eff = (cfg_size > LVL_W'(DEPTH_MAX)) ? LVL_W'(DEPTH_MAX) : cfg_size;

    rxq_occ_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .rd_ack   (rd_ack),
        .ovw_en   (ovw_en),
        .size_eff (size_eff),
        .get_adv  (get_adv),
        .put_adv  (put_adv),
        .lost_evt (lost_evt),
        .full     (full),
        .fill     (fill)
    );

    assign adv_vec = {put_adv, get_adv};

    for (genvar k = 0; k < NUM_IDX; k++) begin : g_idx
        rxq_index_ctr #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv_vec[k]),
            .size_eff (size_eff),
            .idx      (idx_vec[k])
        );
    end

    rxq_lost_flag u_lost (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (lost_evt),
        .clr_req (lost_clr),
        .flag    (lost)
    );

    always_comb begin
        status_word = '0;
        status_word[FILL_LSB +: LVL_W] = fill;
        status_word[GET_LSB  +: IDX_W] = idx_vec[0];
        status_word[PUT_LSB  +: IDX_W] = idx_vec[1];
        status_word[FULL_BIT]          = full;
        status_word[LOST_BIT]          = lost;
    end

endmodule

// File: rtl/rxq_ptr_status_chk.sv
module rxq_ptr_status_chk #(
    parameter int DEPTH_MAX = 64,
    parameter int LVL_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_req,
    input logic             rd_ack,
    input logic [LVL_W-1:0] cfg_size,
    input logic             ovw_en,
    input logic             lost_clr,
    input logic [31:0]      status_word
);

    logic [LVL_W-1:0] s_eff;
    logic [6:0]       c_fill;
    logic             c_full;
    logic             c_lost;
    logic [31:0]      unused_mask;

    assign s_eff       = (cfg_size > LVL_W'(DEPTH_MAX)) ? LVL_W'(DEPTH_MAX) : cfg_size;
    assign c_fill      = status_word[6:0];
    assign c_full      = status_word[24];
    assign c_lost      = status_word[25];
    assign unused_mask = 32'hFCC0_C080;

    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & unused_mask) == 32'h0);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        LVL_W'(c_fill) <= LVL_W'(DEPTH_MAX));

    a_r4_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (c_full == (LVL_W'(c_fill) ==
            (($past(cfg_size) > LVL_W'(DEPTH_MAX)) ? LVL_W'(DEPTH_MAX) : $past(cfg_size)))));

    a_r5_block_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_ack && !ovw_en && c_full && s_eff != '0)
        |=> (c_lost && $stable(status_word[21:0])));

    a_r6_overwrite_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_ack && ovw_en && c_full && s_eff != '0 && !lost_clr)
        |=> ($stable(c_fill) && $stable(c_lost)));

    a_r7_zero_size_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && s_eff == '0) |=> (c_lost && status_word[21:0] == 22'h0));

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_clr && !wr_req) |=> !c_lost);

    a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !wr_req && !lost_clr && c_fill == 7'd0 && s_eff != '0 && !c_full)
        |=> $stable(status_word));

    a_r11_write_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !rd_ack && !c_full && s_eff != '0)
        |=> (c_fill == $past(c_fill) + 7'd1));

endmodule

bind rxq_ptr_status rxq_ptr_status_chk #(.DEPTH_MAX(DEPTH_MAX), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .rd_ack      (rd_ack),
    .cfg_size    (cfg_size),
    .ovw_en      (ovw_en),
    .lost_clr    (lost_clr),
    .status_word (status_word)
);

// File: tb/sim_rxq_ptr_status.sv
`timescale 1ns/1ps
module sim_rxq_ptr_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic        rd_ack = 1'b0;
    logic [6:0]  cfg_size = 7'd8;
    logic        ovw_en = 1'b0;
    logic        lost_clr = 1'b0;
    logic [31:0] status_word;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // reference model state
    int q[$];
    int m_get, m_put, m_full, m_lost, m_seq;

    always #5 clk = ~clk;

    rxq_ptr_status u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_ack(rd_ack),
        .cfg_size(cfg_size), .ovw_en(ovw_en), .lost_clr(lost_clr),
        .status_word(status_word)
    );

    function automatic int eff_size(input int s);
        return (s > 64) ? 64 : s;
    endfunction

    function automatic logic [31:0] model_word();
        logic [31:0] w;
        w = 32'h0;
        w[6:0]   = 7'(q.size());
        w[13:8]  = 6'(m_get);
        w[21:16] = 6'(m_put);
        w[24]    = m_full[0];
        w[25]    = m_lost[0];
        return w;
    endfunction

    task automatic check_word(input string what);
        logic [31:0] exp;
        exp = model_word();
        n_chk++;
        if (status_word !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", cur_req, what, status_word, exp);
        end
    endtask

    task automatic model_edge(input bit w, input bit r, input bit o, input bit c);
        int  s;
        bit  rdv, room, lset;
        s    = eff_size(int'(cfg_size));
        lset = 1'b0;
        if (s == 0) begin
            if (w) lset = 1'b1;
        end else begin
            rdv  = r && (q.size() > 0);
            room = (q.size() < s) || rdv;
            if (rdv) begin
                void'(q.pop_front());
                m_get = (m_get + 1) % s;
            end
            if (w) begin
                if (room) begin
                    q.push_back(m_seq++);
                    m_put = (m_put + 1) % s;
                end else if (o) begin
                    void'(q.pop_front());
                    q.push_back(m_seq++);
                    m_get = (m_get + 1) % s;
                    m_put = (m_put + 1) % s;
                end else begin
                    lset = 1'b1;
                end
            end
        end
        if (lset)   m_lost = 1;
        else if (c) m_lost = 0;
        m_full = (q.size() == s) ? 1 : 0;
    endtask

    task automatic step(input bit w, input bit r, input bit o, input bit c);
        wr_req = w; rd_ack = r; ovw_en = o; lost_clr = c;
        @(posedge clk);
        model_edge(w, r, o, c);
        @(negedge clk);
        check_word("cycle");
    endtask

    task automatic do_reset(input logic [6:0] sz);
        rst_n = 1'b0;
        wr_req = 0; rd_ack = 0; ovw_en = 0; lost_clr = 0;
        cfg_size = sz;
        repeat (2) @(negedge clk);
        q.delete();
        m_get = 0; m_put = 0; m_full = 0; m_lost = 0;
        rst_n = 1'b1;
        cur_req = "R1";
        check_word("after reset");
    endtask

    initial begin
        m_seq = 0;
        @(negedge clk);
        do_reset(7'd8);

        cur_req = "R11";
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0);
        cur_req = "R4";
        step(0, 0, 0, 0);
        cur_req = "R5";
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        cur_req = "R8";
        step(0, 0, 0, 1);
        cur_req = "R12";
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        cur_req = "R6";
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        cur_req = "R2";
        for (int i = 0; i < 8; i++) step(0, 1, 0, 0);
        cur_req = "R10";
        step(0, 1, 0, 0);
        step(0, 1, 1, 0);
        cur_req = "R9";
        for (int i = 0; i < 20; i++) step(1, (i % 3) != 0, 0, 0);
        cur_req = "R8";
        step(1, 0, 0, 0);
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        step(0, 0, 0, 1);

        do_reset(7'd0);
        cur_req = "R7";
        step(0, 0, 0, 0);
        step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 1, 0);
        step(0, 0, 0, 1);

        do_reset(7'd100);
        cur_req = "R13";
        for (int i = 0; i < 64; i++) step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        cur_req = "R3";
        for (int i = 0; i < 70; i++) step(1, 1, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 1, 0, 0);

        do_reset(7'd5);
        cur_req = "R12";
        for (int i = 0; i < 400; i++) begin
            bit w, r, o, c;
            w = ($urandom % 3) != 0;
            r = ($urandom % 2) != 0;
            o = ($urandom % 4) == 0;
            c = ($urandom % 8) == 0;
            step(w, r, o, c);
        end

        do_reset(7'd1);
        cur_req = "R9";
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        step(1, 0, 1, 0);
        step(0, 1, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule